// File: doc/BRIEF.md
# BPSK / Staggered-QPSK I/Q Symbol Front End

This block turns a serial NRZ-L bit stream into two signed bipolar symbol streams, I and Q, for a baseband modulator. Each accepted bit can first pass through a differential precoder. The precoder either leaves the bit as it is or converts it to mark or space coding. The coded bits are then routed to the two channels under a static configuration. In BPSK only I is driven. In staggered QPSK the configuration picks one of three routings:
- copy: one bit goes to both channels;
- split: bits alternate between I and Q;
- dual: Q is fed from a second bit stream with its own strobe.

The Q path can be made to change half a symbol after I, and its sign can be flipped to invert the spectrum.

Symbol timing comes from strobes that pulse at twice the symbol rate. The first strobe pulse after reset is a symbol boundary, and later pulses alternate between mid-symbol and boundary. Both bit inputs are valid/ready streams. A bit transfers on a clock edge where valid and ready are both high. Ready depends only on internal state, never on valid. Each channel holds one bit. Ready stays low from the moment that bit is captured until a boundary strobe consumes it, so the upstream source is paced by the symbol timing. No bit is dropped or taken twice. The symbol outputs carry a one-cycle valid flag and have no back-pressure. The configuration is meant to be changed only while reset is held.

Top module: `iqm_symbol_front`

## Requirements
- R1: During and right after reset, `i_out` and `q_out` are 0, `out_valid` is 0 and `a_ready` is 1.
- R2: `cfg_fmt` selects the precoding of each accepted bit, with a separate level register per input stream that resets to 0.
  - Code 1 (mark): the coded bit is the level XOR the input bit, and the level takes the coded bit.
  - Code 2 (space): the coded bit is the level XOR the inverted input bit, and the level takes the coded bit.
  - Code 0 and codes 3 to 7 pass the bit through and leave the level unchanged.
- R3: A coded bit of 0 drives +AMP and a coded bit of 1 drives -AMP on its channel. AMP defaults to 32767, and both outputs are signed 16-bit.
- R4: With `cfg_sqpsk`=0 (BPSK), each symbol uses one stream-A bit on I, `q_out` stays 0, `b_ready` stays 0, and `cfg_alt`, `cfg_same_src` and `q_tick` have no effect.
- R5: With `cfg_sqpsk`=1, `cfg_alt`=0 and `cfg_same_src`=1 (copy), each symbol takes one stream-A bit and drives it onto both I and Q.
- R6: With `cfg_sqpsk`=1 and `cfg_alt`=1 (split, which takes priority over `cfg_same_src`), the bits of stream A are routed in pairs. The first bit after reset goes to I and the next to Q, and both channels update on the same boundary.
- R7: With `cfg_sqpsk`=1, `cfg_alt`=0 and `cfg_same_src`=0 (dual), Q takes its bits from stream B and its phase from `q_tick`, independently of I. In every other mode `b_ready` is 0 and `q_tick` is ignored.
- R8: Strobe pulses on `i_tick` alternate between boundary and mid-symbol, starting with a boundary after reset. I changes only on boundary pulses.
- R9: With `cfg_qdelay`=1, the Q value taken at a Q boundary appears on the following Q mid-symbol pulse instead. With `cfg_qdelay`=0, Q changes at the boundary.
- R10: With `cfg_qinv`=1, every Q value driven is the negation of its mapped level. With `cfg_qinv`=0, Q is the mapped level unchanged.
- R11: A channel's ready signal stays low while its one-bit holding register is full, until a boundary consumes the bit. A boundary that finds no bit leaves both outputs unchanged and raises no `out_valid`.
- R12: `out_valid` is high for exactly the cycle after a clock edge that changed the I or Q output register, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 3 | Precoding select: 0 level, 1 mark, 2 space, others level |
| cfg_sqpsk | input | 1 | 0 BPSK, 1 staggered QPSK |
| cfg_same_src | input | 1 | In staggered QPSK without split: 1 copy, 0 dual stream |
| cfg_alt | input | 1 | Split stream A alternately onto I and Q |
| cfg_qdelay | input | 1 | Delay Q updates by half a symbol |
| cfg_qinv | input | 1 | Negate Q output |
| i_tick | input | 1 | Strobe at twice the I symbol rate (all modes) |
| q_tick | input | 1 | Strobe at twice the Q symbol rate (dual mode only) |
| a_valid | input | 1 | Stream A bit valid |
| a_ready | output | 1 | Stream A ready |
| a_bit | input | 1 | Stream A NRZ-L bit |
| b_valid | input | 1 | Stream B bit valid |
| b_ready | output | 1 | Stream B ready (dual mode only) |
| b_bit | input | 1 | Stream B NRZ-L bit |
| out_valid | output | 1 | One-cycle flag: a new symbol value is on the outputs |
| i_out | output | 16 | Signed I symbol level |
| q_out | output | 16 | Signed Q symbol level |

## Verification
A precoder level that is flipped inverts every later symbol of its stream. That error shows at the I or Q port on the next boundary that consumes a coded bit, one or two symbols after the fault. A strobe phase register that has slipped makes I change on a mid-symbol pulse, and the out_valid pattern is wrong within one strobe period. A split selector out of step swaps the roles of the I and Q bits, which is visible on the first pair. A holding register that is stuck full or stuck empty shows as a ready signal that never rises or never falls, and therefore as a stalled or duplicated symbol, on the very next boundary.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

  // Precoding codes on cfg_fmt; any other code passes the level through.
  localparam logic [2:0] FMT_MARK  = 3'd1;
  localparam logic [2:0] FMT_SPACE = 3'd2;

  // Number of input bit streams (A feeds I and sometimes Q, B feeds Q in dual mode).
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    RT_SINGLE = 2'd0,  // BPSK: I only
    RT_COPY   = 2'd1,  // one bit to both channels
    RT_SPLIT  = 2'd2,  // stream A alternates I then Q
    RT_DUAL   = 2'd3   // Q from stream B on its own strobe
  } route_t;

endpackage

// File: rtl/iqm_diff_precoder.sv
module iqm_diff_precoder
  import iqm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fmt,
  input  logic       take,
  input  logic       bit_in,
  output logic       bit_out
);

  logic lvl;
  logic diff_mode;

  assign diff_mode = (fmt == FMT_MARK) || (fmt == FMT_SPACE);

  always_comb begin
    case (fmt)
      FMT_MARK:  bit_out = lvl ^ bit_in;
      FMT_SPACE: bit_out = lvl ^ ~bit_in;
      default:   bit_out = bit_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                lvl <= 1'b0;
    else if (take && diff_mode) lvl <= bit_out;
  end

endmodule

// File: rtl/iqm_strobe_phase.sv
module iqm_strobe_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic bnd,
  output logic mid
);

  logic half;  // 0: next pulse is a boundary, 1: next pulse is mid-symbol

  assign bnd = tick && !half;
  assign mid = tick &&  half;

  always_ff @(posedge clk) begin
    if (!rst_n)    half <= 1'b0;
    else if (tick) half <= ~half;
  end

endmodule

// File: rtl/iqm_level_map.sv
module iqm_level_map #(
  parameter int W   = 16,
  parameter int AMP = 32767
) (
  input  logic                bit_in,
  input  logic                neg,
  output logic signed [W-1:0] level
);

  localparam logic signed [W-1:0] POS = W'(AMP);

  logic signed [W-1:0] base;

  assign base  = bit_in ? -POS : POS;
  assign level = neg ? -base : base;

endmodule

// File: rtl/iqm_symbol_front.sv
module iqm_symbol_front
  import iqm_pkg::*;
#(
  parameter int W   = 16,
  parameter int AMP = 32767
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_fmt,
  input  logic                cfg_sqpsk,
  input  logic                cfg_same_src,
  input  logic                cfg_alt,
  input  logic                cfg_qdelay,
  input  logic                cfg_qinv,
  input  logic                i_tick,
  input  logic                q_tick,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic                a_bit,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic                b_bit,
  output logic                out_valid,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] q_out
);

  route_t route;

  always_comb begin
    if (!cfg_sqpsk)        route = RT_SINGLE;
    else if (cfg_alt)      route = RT_SPLIT;
    else if (cfg_same_src) route = RT_COPY;
    else                   route = RT_DUAL;
  end

  // Strobe phases: I strobe always, Q strobe only used in dual mode.
  logic i_bnd, i_mid, qs_bnd, qs_mid, q_bnd, q_mid;

  iqm_strobe_phase u_iph (.clk(clk), .rst_n(rst_n), .tick(i_tick), .bnd(i_bnd),  .mid(i_mid));
  iqm_strobe_phase u_qph (.clk(clk), .rst_n(rst_n), .tick(q_tick), .bnd(qs_bnd), .mid(qs_mid));

  assign q_bnd = (route == RT_DUAL) ? qs_bnd : i_bnd;
  assign q_mid = (route == RT_DUAL) ? qs_mid : i_mid;

  // Holding registers
  logic i_buf_v, i_buf, q_buf_v, q_buf, sel, stg_v, stg;
  logic a_take, b_take;

  assign a_ready = (route == RT_SPLIT && sel) ? !q_buf_v : !i_buf_v;
  assign b_ready = (route == RT_DUAL) && !q_buf_v;
  assign a_take  = a_valid && a_ready;
  assign b_take  = b_valid && b_ready;

  // One precoder per input stream
  logic [NUM_SRC-1:0] src_take, src_bit, src_enc;

  assign src_take = {b_take, a_take};
  assign src_bit  = {b_bit,  a_bit};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pre
    iqm_diff_precoder u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .fmt    (cfg_fmt),
      .take   (src_take[g]),
      .bit_in (src_bit[g]),
      .bit_out(src_enc[g])
    );
  end

  // Release decisions
  logic i_fire, q_avail, q_bit, q_direct, q_late, q_sel_bit;

  assign i_fire = i_bnd && i_buf_v && ((route != RT_SPLIT) || q_buf_v);

  always_comb begin
    case (route)
      RT_COPY:  begin q_avail = i_fire;            q_bit = i_buf; end
      RT_SPLIT: begin q_avail = i_fire;            q_bit = q_buf; end
      RT_DUAL:  begin q_avail = q_bnd && q_buf_v;  q_bit = q_buf; end
      default:  begin q_avail = 1'b0;              q_bit = 1'b0;  end
    endcase
  end

  assign q_direct  = q_avail && !cfg_qdelay;
  assign q_late    = cfg_qdelay && q_mid && stg_v;
  assign q_sel_bit = q_direct ? q_bit : stg;

  logic signed [W-1:0] i_lvl, q_lvl;

  iqm_level_map #(.W(W), .AMP(AMP)) u_imap (.bit_in(i_buf),     .neg(1'b0),     .level(i_lvl));
  iqm_level_map #(.W(W), .AMP(AMP)) u_qmap (.bit_in(q_sel_bit), .neg(cfg_qinv), .level(q_lvl));

  // Sequential state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_buf_v   <= 1'b0;
      i_buf     <= 1'b0;
      q_buf_v   <= 1'b0;
      q_buf     <= 1'b0;
      sel       <= 1'b0;
      stg_v     <= 1'b0;
      stg       <= 1'b0;
      i_out     <= '0;
      q_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      // split selector: I slot first after reset
      if (route != RT_SPLIT) sel <= 1'b0;
      else if (a_take)       sel <= ~sel;

      // I holding register
      if (i_fire) i_buf_v <= 1'b0;
      if (a_take && !(route == RT_SPLIT && sel)) begin
        i_buf_v <= 1'b1;
        i_buf   <= src_enc[0];
      end

      // Q holding register (split and dual only)
      if ((route == RT_SPLIT && i_fire) || (route == RT_DUAL && q_avail)) q_buf_v <= 1'b0;
      if (a_take && route == RT_SPLIT && sel) begin
        q_buf_v <= 1'b1;
        q_buf   <= src_enc[0];
      end
      if (b_take) begin
        q_buf_v <= 1'b1;
        q_buf   <= src_enc[1];
      end

      // half-symbol stage for Q
      if (q_avail && cfg_qdelay) begin
        stg_v <= 1'b1;
        stg   <= q_bit;
      end else if (q_late) begin
        stg_v <= 1'b0;
      end

      if (i_fire)               i_out <= i_lvl;
      if (q_direct || q_late)   q_out <= q_lvl;
      out_valid <= i_fire || q_direct || q_late;
    end
  end

endmodule

// File: rtl/iqm_symbol_front_chk.sv
module iqm_symbol_front_chk #(
  parameter int W   = 16,
  parameter int AMP = 32767
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_sqpsk,
  input logic                cfg_same_src,
  input logic                cfg_alt,
  input logic                cfg_qdelay,
  input logic                cfg_qinv,
  input logic                i_tick,
  input logic                q_tick,
  input logic                a_ready,
  input logic                b_ready,
  input logic                out_valid,
  input logic signed [W-1:0] i_out,
  input logic signed [W-1:0] q_out
);

  localparam logic signed [W-1:0] POS = W'(AMP);
  localparam logic signed [W-1:0] NEG = -POS;

  logic copy_mode, dual_mode, single_strobe_sq;

  assign copy_mode        = cfg_sqpsk && !cfg_alt && cfg_same_src;
  assign dual_mode        = cfg_sqpsk && !cfg_alt && !cfg_same_src;
  assign single_strobe_sq = cfg_sqpsk && !dual_mode;

  AST_BPSK_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sqpsk |-> (q_out == '0)); // R4

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (i_out == POS || i_out == NEG)); // R3

  AST_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> !b_ready); // R7

  AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(i_tick || q_tick)); // R12

  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_mode && !cfg_qdelay && out_valid) |-> (q_out == (cfg_qinv ? -i_out : i_out))); // R5

  AST_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (single_strobe_sq && cfg_qdelay && out_valid)
      |-> !((i_out != $past(i_out)) && (q_out != $past(q_out)))); // R9

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ready && !i_tick) |=> !a_ready); // R11

endmodule

bind iqm_symbol_front iqm_symbol_front_chk #(.W(W), .AMP(AMP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_sqpsk   (cfg_sqpsk),
  .cfg_same_src(cfg_same_src),
  .cfg_alt     (cfg_alt),
  .cfg_qdelay  (cfg_qdelay),
  .cfg_qinv    (cfg_qinv),
  .i_tick      (i_tick),
  .q_tick      (q_tick),
  .a_ready     (a_ready),
  .b_ready     (b_ready),
  .out_valid   (out_valid),
  .i_out       (i_out),
  .q_out       (q_out)
);

// File: tb/iqm_symbol_front_test.sv
`timescale 1ns/1ps
module iqm_symbol_front_test;

  localparam logic signed [15:0] AMP = 16'sd32767;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_fmt = '0;
  logic cfg_sqpsk = 0, cfg_same_src = 0, cfg_alt = 0, cfg_qdelay = 0, cfg_qinv = 0;
  logic i_tick = 0, q_tick = 0;
  logic a_valid = 0, a_bit = 0, b_valid = 0, b_bit = 0;
  logic a_ready, b_ready, out_valid;
  logic signed [15:0] i_out, q_out;

  int total = 0, bad = 0;
  int na, nb;
  int cfg_c = 0;
  logic feed_en = 1'b0;
  logic done = 1'b0;

  iqm_symbol_front uut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_sqpsk(cfg_sqpsk),
    .cfg_same_src(cfg_same_src), .cfg_alt(cfg_alt), .cfg_qdelay(cfg_qdelay),
    .cfg_qinv(cfg_qinv), .i_tick(i_tick), .q_tick(q_tick),
    .a_valid(a_valid), .a_ready(a_ready), .a_bit(a_bit),
    .b_valid(b_valid), .b_ready(b_ready), .b_bit(b_bit),
    .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
  );

  always #2 clk = ~clk;

  function automatic logic abit(input int c, input int k);
    return ((k * k + 3 * k + c) % 7) < 3;
  endfunction

  function automatic logic bbit(input int c, input int k);
    return ((k * 5 + c) % 3) == 0;
  endfunction

  function automatic logic signed [15:0] mapv(input logic b, input logic neg);
    logic signed [15:0] v;
    v = b ? -AMP : AMP;
    return neg ? -v : v;
  endfunction

  // transfer counters: sampled at the edge, before the design's registers move
  always @(posedge clk) begin
    if (!rst_n) begin na <= 0; nb <= 0; end
    else begin
      if (a_valid && a_ready) na <= na + 1;
      if (b_valid && b_ready) nb <= nb + 1;
    end
  end

  always @(negedge clk) begin
    a_valid <= feed_en;
    a_bit   <= abit(cfg_c, na);
    b_valid <= feed_en;
    b_bit   <= bbit(cfg_c, nb);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cfg=%0d)", tag, act, exp_v, cfg_c);
    end
  endtask

  task automatic pulse(input logic qt);
    @(negedge clk); i_tick = 1'b1; q_tick = qt;
    @(negedge clk); i_tick = 1'b0; q_tick = 1'b0;
  endtask

  task automatic encode(input logic [2:0] f, input bit use_b, output logic e [16]);
    logic st;
    logic b;
    st = 1'b0;
    for (int k = 0; k < 16; k++) begin
      b = use_b ? bbit(cfg_c, k) : abit(cfg_c, k);
      if (f == 3'd1)      begin st = st ^ b;  e[k] = st; end
      else if (f == 3'd2) begin st = st ^ ~b; e[k] = st; end
      else                e[k] = b;
    end
  endtask

  task automatic run_cfg(input int c);
    logic encA [16];
    logic encB [16];
    logic sq, split, copy, dual, dly, inv;
    int ti, tq, s, qidx;
    bit ib, qup, qt;
    logic qb;
    logic signed [15:0] iexp, qexp;
    string itag, qtag;

    cfg_c = c; feed_en = 1'b0; rst_n = 1'b0;
    cfg_fmt = 3'(c & 3); cfg_sqpsk = c[2]; cfg_same_src = c[3];
    cfg_alt = c[4]; cfg_qdelay = c[5]; cfg_qinv = c[6];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    sq = cfg_sqpsk; dly = cfg_qdelay; inv = cfg_qinv;
    split = sq && cfg_alt;
    copy  = sq && !cfg_alt && cfg_same_src;
    dual  = sq && !cfg_alt && !cfg_same_src;
    encode(cfg_fmt, 1'b0, encA);
    encode(cfg_fmt, 1'b1, encB);

    // R1 reset state
    chk(i_out == 0 && q_out == 0, "R1 outputs", int'(i_out) + int'(q_out), 0);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(a_ready == 1, "R1 a_ready", int'(a_ready), 1);
    // R4/R7 second stream only open in dual mode
    chk(b_ready == dual, "R4/R7 b_ready", int'(b_ready), int'(dual));

    itag = split ? "R2/R3/R6/R8 I" : "R2/R3/R8 I";
    qtag = !sq ? "R4" : copy ? "R5" : split ? "R6" : "R7";
    if (dly) qtag = {qtag, "/R9"};
    if (inv) qtag = {qtag, "/R10"};
    qtag = {"R2/", qtag, " Q"};

    feed_en = 1'b1;
    repeat (4) @(negedge clk);

    ti = 0; tq = 0; iexp = 0; qexp = 0;
    for (int t = 0; t < 8; t++) begin
      qt = (t % 3) != 2;
      pulse(qt);
      ib = (ti % 2) == 0;
      if (ib) begin
        s = ti / 2;
        iexp = mapv(split ? encA[2 * s] : encA[s], 1'b0);
      end
      qidx = -1;
      if (dual) begin
        if (qt) begin qidx = tq; tq++; end
      end else begin
        qidx = ti;
      end
      ti++;
      qup = 1'b0;
      if (sq && qidx >= 0) begin
        if (!dly && (qidx % 2) == 0)      begin s = qidx / 2;       qup = 1'b1; end
        else if (dly && (qidx % 2) == 1)  begin s = (qidx - 1) / 2; qup = 1'b1; end
        if (qup) begin
          qb = copy ? encA[s] : split ? encA[2 * s + 1] : encB[s];
          qexp = mapv(qb, inv);
        end
      end
      chk(i_out == iexp, itag, int'(i_out), int'(iexp));
      chk(q_out == qexp, qtag, int'(q_out), int'(qexp));
      chk(out_valid == (ib || qup), "R12 out_valid pulse", int'(out_valid), int'(ib || qup));
      @(negedge clk);
      chk(out_valid == 0, "R12 out_valid single", int'(out_valid), 0);
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 128; c++) run_cfg(c);

    // R11: starved boundary, then back-pressure with no strobe
    cfg_c = 5; feed_en = 1'b0; rst_n = 1'b0;
    cfg_fmt = 3'd0; cfg_sqpsk = 0; cfg_same_src = 0; cfg_alt = 0; cfg_qdelay = 0; cfg_qinv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      pulse(1'b0);
      chk(out_valid == 0, "R11 empty boundary valid", int'(out_valid), 0);
      chk(i_out == 0, "R11 empty boundary hold", int'(i_out), 0);
      repeat (3) @(negedge clk);
    end
    feed_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(a_ready == 0, "R11 ready low when full", int'(a_ready), 0);
    chk(na == 1, "R11 single bit taken", na, 1);
    pulse(1'b0);
    chk(i_out == mapv(abit(5, 0), 1'b0), "R8/R11 first bit after stall", int'(i_out),
        int'(mapv(abit(5, 0), 1'b0)));
    repeat (4) @(negedge clk);
    chk(na == 2, "R11 next bit once", na, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule